// File: doc/BRIEF.md
# Three-wire serial EEPROM slave model

This block models a small serial EEPROM of 16 words of 16 bits. A host reaches it through four synchronous signals: a chip select, a serial clock, a serial data input and a serial data output with a separate output-enable. The serial clock and data are sampled with the system clock, so the host must hold each serial clock level for several system clocks. Every instruction begins with a start bit. A two-bit opcode and a six-bit address field follow, and data comes after them when the instruction needs it. The block can read a word, write a word, erase a word, erase the whole array, write one word into every location, and turn write permission on or off.

A programming instruction begins its self-timed cycle when chip select falls after the last bit has arrived. While that cycle runs, the data output shows busy (0) whenever chip select is high, and serial input is ignored. Once the cycle ends it shows ready (1). The array is held in a memory that can map onto block RAM. The bulk operations step through it one word at a time inside the busy window. A parameter adds a mandatory dummy clock at the head of every instruction.

Top module: `mw_eeprom`

## Requirements
- R1: With DUMMY_CLK=0, the first rising serial clock with din=1 while cs is high is the start bit. The next 2 bits form the opcode and the next 6 bits form the address field, all MSB first. Opcode 10 is read, 01 is write, 11 is erase and 00 is the extended group. For an extended instruction, address bits [5:4] select 11 write-enable, 00 write-disable, 10 erase-all or 01 write-all. Otherwise only address bits [3:0] pick the word and bits [5:4] are ignored.
- R2: After reset, and after a write-disable, every programming instruction is discarded with no busy period until a write-enable executes.
- R3: After the last address bit of a read, dout shows a 0 dummy bit. Each later rising serial clock then presents the next bit of the word, MSB first. Every dout change appears within two system clocks of the serial clock edge.
- R4: Write replaces the addressed word with the 16 data bits that follow the address. Erase sets the addressed word to 16'hFFFF.
- R5: Erase-all sets every word to 16'hFFFF, and its address bits [3:0] are ignored.
- R6: Write-all replaces every word with the bitwise AND of its old value and the data word, with no erase first.
- R7: A programming cycle starts only when cs falls after a complete instruction, which includes all 16 data bits for write and write-all. If cs falls earlier, the instruction is discarded.
- R8: For max(PROG_CYCLES, 2*16) system clocks after a cycle starts, dout is 0 while cs is high, and rising serial clocks have no effect.
- R9: dout_oe follows cs one system clock later, and dout is 0 when dout_oe is 0. While cs is high and not busy, dout is 1 until a start bit is decoded. It then drops to 0 for the rest of the frame unless read data is being shifted.
- R10: With DUMMY_CLK=1, the first rising serial clock after cs rises is discarded whatever din is, and dout stays 1 through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock, sampled by clk |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out / ready-busy |
| dout_oe | output | 1 | Drive enable for dout (high impedance when 0) |

## Verification
The bench targets the corner cases where a wrong design gives a plausible but wrong answer. An erase frame is clocked in during busy: a design that listens during busy would erase the word. Chip select is dropped after only eight data bits: a design that arms too early would write a partial word. Write-all is issued without a prior erase-all: a design that erases first would return the data word instead of the AND with stale ones. A write frame uses address bits [5:4] = 11: a design that decodes those bits would hit the wrong word or the extended group. Finally, two instances are driven by one dummy clock with din=1. The instance without the dummy clock must treat it as a start bit, and the instance with it must still read the right word.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    FE_DUMMY, FE_START, FE_OP, FE_ADDR, FE_DATA, FE_READ, FE_HOLD
  } fe_state_e;

  typedef enum logic [1:0] {
    PK_WRITE, PK_ERASE, PK_ERAL, PK_WRAL
  } prog_kind_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EX_WDIS = 2'b00;
  localparam logic [1:0] EX_WALL = 2'b01;
  localparam logic [1:0] EX_EALL = 2'b10;
  localparam logic [1:0] EX_WEN  = 2'b11;
endpackage

// File: rtl/mw_word_mem.sv
module mw_word_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/mw_prog_engine.sv
module mw_prog_engine import mw_pkg::*; #(
  parameter int DW          = 16,
  parameter int AW          = 4,
  parameter int PROG_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  prog_kind_e    kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic [AW-1:0] raddr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata
);
  localparam int DEPTH    = 1 << AW;
  localparam int SWEEP    = 2 * DEPTH;
  localparam int BUSY_LEN = (PROG_CYCLES > SWEEP) ? PROG_CYCLES : SWEEP;
  localparam int CNTW     = $clog2(BUSY_LEN) + 1;

  logic [CNTW-1:0] cnt;
  prog_kind_e      kind_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [AW-1:0]   idx;
  logic            in_sweep;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      kind_q <= PK_WRITE;
      addr_q <= '0;
      data_q <= '0;
    end else if (!busy) begin
      if (req) begin
        busy   <= 1'b1;
        cnt    <= '0;
        kind_q <= kind;
        addr_q <= addr;
        data_q <= data;
      end
    end else begin
      if (cnt == CNTW'(BUSY_LEN - 1)) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign idx      = cnt[AW:1];
  assign in_sweep = cnt < CNTW'(SWEEP);
  assign raddr    = idx;

  always_comb begin
    we    = 1'b0;
    waddr = addr_q;
    wdata = data_q;
    if (busy && in_sweep) begin
      unique case (kind_q)
        PK_WRITE: we = (cnt == '0);
        PK_ERASE: begin
          we    = (cnt == '0);
          wdata = '1;
        end
        PK_ERAL: begin
          we    = cnt[0];
          waddr = idx;
          wdata = '1;
        end
        PK_WRAL: begin
          we    = cnt[0];
          waddr = idx;
          wdata = rd_data & data_q;
        end
      endcase
    end
  end

  // R8
  req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> !busy);

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cnt) == CNTW'(BUSY_LEN - 1));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req));
endmodule

// File: rtl/mw_serial_fe.sv
module mw_serial_fe import mw_pkg::*; #(
  parameter int DW        = 16,
  parameter int AW        = 4,
  parameter int FA        = 6,
  parameter bit DUMMY_CLK = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          sck,
  input  logic          din,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] fe_raddr,
  output logic          prog_req,
  output prog_kind_e    prog_kind,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          ready_win,
  output logic          in_read,
  output logic          rd_bit
);
  localparam int CW = $clog2(DW);
  localparam fe_state_e INIT = DUMMY_CLK ? FE_DUMMY : FE_START;

  fe_state_e     state;
  logic [CW-1:0] cnt;
  logic [1:0]    op;
  logic [FA-1:0] addr_sh;
  logic [FA-1:0] addr_full;
  logic [DW-1:0] data_sh;
  logic          armed;
  logic          wen;
  logic          rd_active;
  logic          sck_q;
  logic          rise;
  logic [DW-1:0] bit_mask;

  assign rise      = sck && !sck_q;
  assign addr_full = {addr_sh[FA-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= INIT;
      cnt       <= '0;
      op        <= '0;
      addr_sh   <= '0;
      data_sh   <= '0;
      armed     <= 1'b0;
      wen       <= 1'b0;
      rd_active <= 1'b0;
      sck_q     <= 1'b0;
      prog_req  <= 1'b0;
      prog_kind <= PK_WRITE;
    end else begin
      sck_q    <= sck;
      prog_req <= 1'b0;
      if (!cs) begin
        state     <= INIT;
        armed     <= 1'b0;
        rd_active <= 1'b0;
        cnt       <= '0;
        if (armed && wen && !busy) prog_req <= 1'b1;
      end else if (rise && !busy) begin
        unique case (state)
          FE_DUMMY: state <= FE_START;
          FE_START: if (din) begin
            state <= FE_OP;
            cnt   <= '0;
          end
          FE_OP: begin
            op  <= {op[0], din};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(1)) begin
              state <= FE_ADDR;
              cnt   <= '0;
            end
          end
          FE_ADDR: begin
            addr_sh <= addr_full;
            cnt     <= cnt + 1'b1;
            if (cnt == CW'(FA - 1)) begin
              cnt   <= '0;
              state <= FE_HOLD;
              unique case (op)
                OP_READ: begin
                  state     <= FE_READ;
                  rd_active <= 1'b0;
                end
                OP_WRITE: begin
                  prog_kind <= PK_WRITE;
                  state     <= FE_DATA;
                end
                OP_ERASE: begin
                  prog_kind <= PK_ERASE;
                  armed     <= 1'b1;
                end
                OP_EXT: begin
                  unique case (addr_full[FA-1:FA-2])
                    EX_WEN:  wen <= 1'b1;
                    EX_WDIS: wen <= 1'b0;
                    EX_EALL: begin
                      prog_kind <= PK_ERAL;
                      armed     <= 1'b1;
                    end
                    EX_WALL: begin
                      prog_kind <= PK_WRAL;
                      state     <= FE_DATA;
                    end
                  endcase
                end
              endcase
            end
          end
          FE_DATA: begin
            data_sh <= {data_sh[DW-2:0], din};
            cnt     <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) begin
              armed <= 1'b1;
              state <= FE_HOLD;
            end
          end
          FE_READ: begin
            if (!rd_active) begin
              rd_active <= 1'b1;
              cnt       <= '0;
            end else if (cnt == CW'(DW - 1)) begin
              rd_active <= 1'b0;
              state     <= FE_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FE_HOLD: state <= FE_HOLD;
        endcase
      end
    end
  end

  assign bit_mask  = {1'b1, {(DW-1){1'b0}}} >> cnt;
  assign rd_bit    = |(rd_data & bit_mask);
  assign in_read   = (state == FE_READ) && rd_active;
  assign ready_win = (state == FE_DUMMY) || (state == FE_START);
  assign fe_raddr  = addr_sh[AW-1:0];
  assign prog_addr = addr_sh[AW-1:0];
  assign prog_data = data_sh;

  // R8
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(cs)) |-> state == $past(state));

  // R10
  frame_init_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cs) |-> state == INIT);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom import mw_pkg::*; #(
  parameter int DW          = 16,
  parameter int AW          = 4,
  parameter int FA          = 6,
  parameter int PROG_CYCLES = 64,
  parameter bit DUMMY_CLK   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sck,
  input  logic din,
  output logic dout,
  output logic dout_oe
);
  logic [DW-1:0] rd_data;
  logic [AW-1:0] fe_raddr;
  logic [AW-1:0] eng_raddr;
  logic [AW-1:0] mem_raddr;
  logic          prog_req;
  prog_kind_e    prog_kind;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic          ready_win;
  logic          in_read;
  logic          rd_bit;
  logic          busy;
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  mw_serial_fe #(.DW(DW), .AW(AW), .FA(FA), .DUMMY_CLK(DUMMY_CLK)) u_fe (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .din(din), .busy(busy),
    .rd_data(rd_data), .fe_raddr(fe_raddr), .prog_req(prog_req),
    .prog_kind(prog_kind), .prog_addr(prog_addr), .prog_data(prog_data),
    .ready_win(ready_win), .in_read(in_read), .rd_bit(rd_bit)
  );

  mw_prog_engine #(.DW(DW), .AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .req(prog_req), .kind(prog_kind),
    .addr(prog_addr), .data(prog_data), .rd_data(rd_data), .busy(busy),
    .raddr(eng_raddr), .we(we), .waddr(waddr), .wdata(wdata)
  );

  assign mem_raddr = busy ? eng_raddr : fe_raddr;

  mw_word_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(mem_raddr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= cs;
      dout    <= cs && !busy && (ready_win || (in_read && rd_bit));
    end
  end

  // R8
  busy_out_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && $past(cs)) |-> !dout);

  // R9
  hiz_low_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> !dout);
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int PROG = 300;
  localparam int WAITR = PROG + 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sck = 1'b0, din = 1'b0;
  logic dout, dout_oe, dout_dm, oe_dm;
  logic cs_seen = 1'b0;
  int tests = 0, fails = 0;
  logic [15:0] exp_mem [16];
  bit exp_wen = 0;

  always #5 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG), .DUMMY_CLK(1'b0)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .din(din),
    .dout(dout), .dout_oe(dout_oe));

  mw_eeprom #(.PROG_CYCLES(PROG), .DUMMY_CLK(1'b1)) u_dut_dm (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .din(din),
    .dout(dout_dm), .dout_oe(oe_dm));

  always @(posedge clk) cs_seen <= rst ? 1'b0 : cs;

  // R9: per-clock check of the drive enable and tri-state level
  always @(negedge clk) if (!rst) begin
    tests++;
    if (dout_oe !== cs_seen || oe_dm !== cs_seen ||
        (!dout_oe && dout !== 1'b0)) begin
      fails++;
      $display("FAIL R9 oe=%b oe_dm=%b dout=%b expected oe=%b", dout_oe, oe_dm, dout, cs_seen);
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); sck = 1'b0; din = b;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sbits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic cs_up();
    @(negedge clk); cs = 1'b1; sck = 1'b0; din = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; sck = 1'b0; din = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Full instruction; lead<0 means no leading dummy pulse; ndata data bits sent
  task automatic frame(input int lead, input logic [1:0] op, input logic [5:0] a,
                       input int ndata, input logic [15:0] d);
    cs_up();
    if (lead >= 0) sbit(lead[0]);
    sbit(1'b1);
    sbits({14'd0, op}, 2);
    sbits({10'd0, a}, 6);
    if (ndata > 0) sbits(d >> (16 - ndata), ndata);
    cs_down();
  endtask

  // Reference model update for a completed programming frame
  task automatic model(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
    if (op == 2'b00 && a[5:4] == 2'b11) exp_wen = 1;
    else if (op == 2'b00 && a[5:4] == 2'b00) exp_wen = 0;
    else if (exp_wen) begin
      if (op == 2'b01) exp_mem[a[3:0]] = d;
      else if (op == 2'b11) exp_mem[a[3:0]] = 16'hFFFF;
      else if (op == 2'b00 && a[5:4] == 2'b10) for (int i = 0; i < 16; i++) exp_mem[i] = 16'hFFFF;
      else if (op == 2'b00 && a[5:4] == 2'b01) for (int i = 0; i < 16; i++) exp_mem[i] = exp_mem[i] & d;
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
    int nd;
    nd = (op == 2'b01 || (op == 2'b00 && a[5:4] == 2'b01)) ? 16 : 0;
    frame(-1, op, a, nd, d);
    model(op, a, d);
    repeat (WAITR) @(negedge clk);
  endtask

  task automatic rd(input string req, input int lead, input bit use_dm,
                    input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] w;
    cs_up();
    if (lead >= 0) sbit(lead[0]);
    sbit(1'b1);
    sbits(16'd2, 2);
    sbits({10'd0, a}, 6);
    chk({req, " R3 dummy bit"}, {15'd0, use_dm ? dout_dm : dout}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      sbit(1'b0);
      w[i] = use_dm ? dout_dm : dout;
    end
    cs_down();
    chk(req, w, exp);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 reset oe", {15'd0, dout_oe}, 16'd0);
    chk("R9 reset dout", {15'd0, dout}, 16'd0);

    cs_up();
    chk("R9 idle ready", {15'd0, dout}, 16'd1);
    cs_down();

    // R2: write without enable is discarded, no busy
    frame(-1, 2'b01, 6'd1, 16, 16'h1234);
    model(2'b01, 6'd1, 16'h1234);
    cs_up();
    chk("R2 no busy without enable", {15'd0, dout}, 16'd1);
    cs_down();

    cmd(2'b00, 6'b110000, 16'h0);
    // R8/R9: erase-all busy then ready, ready cleared by start bit
    frame(-1, 2'b00, 6'b100111, 0, 16'h0);
    model(2'b00, 6'b100111, 16'h0);
    cs_up();
    chk("R8 busy on erase-all", {15'd0, dout}, 16'd0);
    repeat (WAITR) @(negedge clk);
    chk("R9 ready after cycle", {15'd0, dout}, 16'd1);
    sbit(1'b1);
    chk("R9 start bit clears ready", {15'd0, dout}, 16'd0);
    cs_down();

    rd("R5 erase-all word 0", -1, 0, 6'd0, 16'hFFFF);
    rd("R5 erase-all word 15", -1, 0, 6'd15, 16'hFFFF);

    // R1: upper address bits ignored on a write; R4 writes
    cmd(2'b01, 6'b110101, 16'hA5C3);
    cmd(2'b01, 6'd9, 16'h0F0F);
    rd("R1 R4 word 5", -1, 0, 6'd5, exp_mem[5]);
    rd("R4 word 9", -1, 0, 6'd9, exp_mem[9]);
    rd("R4 word 0 untouched", -1, 0, 6'd0, exp_mem[0]);

    // R8: erase frame during busy is ignored
    frame(-1, 2'b01, 6'd9, 16, 16'h1234);
    model(2'b01, 6'd9, 16'h1234);
    cs_up();
    sbit(1'b1); sbits(16'd3, 2); sbits(16'd9, 6);
    cs_down();
    repeat (WAITR) @(negedge clk);
    rd("R8 input ignored while busy", -1, 0, 6'd9, 16'h1234);

    cmd(2'b11, 6'd5, 16'h0);
    rd("R4 erase word 5", -1, 0, 6'd5, 16'hFFFF);
    rd("R4 erase leaves word 9", -1, 0, 6'd9, exp_mem[9]);

    // R7: truncated write discarded
    frame(-1, 2'b01, 6'd9, 8, 16'h0000);
    cs_up();
    chk("R7 truncated write no busy", {15'd0, dout}, 16'd1);
    cs_down();
    rd("R7 truncated write data", -1, 0, 6'd9, 16'h1234);

    // R6: write-all without erase leaves stale ones
    cmd(2'b00, 6'b010000, 16'h00FF);
    rd("R6 AND into word 9", -1, 0, 6'd9, exp_mem[9]);
    rd("R6 AND into word 5", -1, 0, 6'd5, exp_mem[5]);

    // R2: disable blocks erase
    cmd(2'b00, 6'b000000, 16'h0);
    frame(-1, 2'b11, 6'd9, 0, 16'h0);
    model(2'b11, 6'd9, 16'h0);
    cs_up();
    chk("R2 disabled erase no busy", {15'd0, dout}, 16'd1);
    cs_down();
    rd("R2 disabled erase data", -1, 0, 6'd9, exp_mem[9]);

    cmd(2'b00, 6'b110000, 16'h0);
    cmd(2'b00, 6'b100000, 16'h0);
    cmd(2'b00, 6'b010000, 16'hC33C);
    rd("R5 R6 erase then write-all", -1, 0, 6'd7, exp_mem[7]);

    // R10: dummy-clock instance
    frame(0, 2'b00, 6'b110000, 0, 16'h0);
    repeat (WAITR) @(negedge clk);
    frame(0, 2'b00, 6'b100000, 0, 16'h0);
    repeat (WAITR) @(negedge clk);
    frame(0, 2'b01, 6'd3, 16, 16'h5A3C);
    repeat (WAITR) @(negedge clk);
    cs_up();
    sbit(1'b1);
    chk("R10 dummy pulse keeps ready", {15'd0, dout_dm}, 16'd1);
    chk("R1 no-dummy part takes it as start", {15'd0, dout}, 16'd0);
    cs_down();
    repeat (WAITR) @(negedge clk);
    rd("R10 read after dummy D=1", 1, 1, 6'd3, 16'h5A3C);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule